// File: doc/BRIEF.md
# Serial Bit-Pattern Pin Driver

This block plays a packed bit pattern out on one output pin. Software or a neighbouring engine first fills a small byte buffer through a simple write port. It then supplies a bit count and a per-bit hold count, and strobes `start`. The block walks the buffer most-significant bit first within each byte, drives the pin to each bit value in turn, and holds every bit for a fixed number of clock cycles. The bit count does not need to land on a byte boundary.

While a pattern is playing, the block owns the pin. A direct pin write, a buffer write or a second start cannot disturb the sequence. When the last bit has been held for its full time, `busy` drops and `done` pulses once. The pin then stays at the last level it drove until it is written again.

Top module: `bitpat_tx`

## Requirements
- R1: Pattern bit i comes from buffer byte address i/8 at bit position 7-(i mod 8), so bit 7 of each byte is sent first. A 1 drives `pin_out` high and a 0 drives it low. Any bit count is honoured, including counts that are not a multiple of 8.
- R2: A start accepted while idle makes `busy` high and drives pattern bit 0 on `pin_out` on the first clock edge after the strobe. Each bit stays on the pin for `hold_cycles`+1 clock cycles, so a hold of 0 gives one cycle per bit.
- R3: For an effective length L ≥ 1 and hold d, `busy` stays high for exactly L*(d+1) cycles. On the edge where `busy` falls, `done` rises, and `done` stays high for exactly one cycle.
- R4: After the last bit has been sent, `pin_out` keeps the level of that bit.
- R5: A start with `bit_count` = 0 gives a one-cycle `done` on the next edge. `busy` never rises and `pin_out` does not change.
- R6: A `bit_count` above 256 (the 32-byte buffer capacity) is clipped to 256 bits.
- R7: A start strobe while `busy` is high is ignored. The pattern in progress keeps its bits and its timing.
- R8: When idle, `pin_set_en` loads `pin_set_val` into `pin_out` on the next edge. While `busy` is high, `pin_set_en` has no effect.
- R9: A buffer write (`buf_wr_en`) while `busy` is high is ignored. A buffer write while idle stores the byte.
- R10: Reset drives `pin_out`, `busy` and `done` low and clears every buffer byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr_en | input | 1 | Write one buffer byte |
| buf_wr_addr | input | 5 | Byte address in the buffer |
| buf_wr_data | input | 8 | Byte value to store |
| bit_count | input | 16 | Number of bits to send, sampled at start |
| hold_cycles | input | 16 | Extra hold cycles per bit, sampled at start |
| start | input | 1 | Launch strobe |
| pin_set_en | input | 1 | Direct pin write strobe, honoured only when idle |
| pin_set_val | input | 1 | Level for a direct pin write |
| pin_out | output | 1 | Driven pin level |
| busy | output | 1 | High while a pattern is playing |
| done | output | 1 | One-cycle pulse when a pattern ends |

## Verification
Every output is registered, so each result appears one edge after its cause. Bit 0 and `busy` show one cycle after the accepted start. Bit k shows k*(d+1) cycles after that. `done` appears L*(d+1) cycles after bit 0 and clears on the following cycle, and a zero-length start gives `done` after a single edge. The bench drives all inputs and samples all outputs at the falling edge, and steps one falling edge for each expected cycle. This lets it compare the pin, `busy` and `done` against its own buffer model on every cycle of every pattern, including runs with a start, pin write or buffer write injected part way through.

// File: rtl/bitpat_pkg.sv
package bitpat_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bitpat_buf.sv
// Byte buffer with a single write port and a bit-granular read port.
module bitpat_buf #(
    parameter int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int IDX_W = $clog2(DEPTH * 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             lock,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    logic [DEPTH-1:0][7:0] mem_d, mem_q;
    logic [AW-1:0]         byte_sel;
    logic [2:0]            bit_pos;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && !lock) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Most significant bit of each byte is sent first.
    always_comb begin
        byte_sel = rd_idx[IDX_W-1:3];
        bit_pos  = 3'd7 - rd_idx[2:0];
        rd_bit   = mem_q[byte_sel][bit_pos];
    end

endmodule

// File: rtl/bitpat_seq.sv
// Run controller: walks the bit index and times each bit.
module bitpat_seq
    import bitpat_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int DLY_W    = 16,
    parameter int MAX_BITS = 256,
    localparam int IDX_W   = $clog2(MAX_BITS),
    localparam int CNT_W   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] bit_count,
    input  logic [DLY_W-1:0] hold_cycles,
    output logic             busy,
    output logic             done,
    output logic             emit,
    output logic [IDX_W-1:0] rd_idx
);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] dly;
        logic             done;
    } seq_t;

    seq_t             s_d, s_q;
    logic [CNT_W-1:0] eff_len;

    // Clip the requested count to the buffer capacity.
    always_comb begin
        if (bit_count > LEN_W'(MAX_BITS)) begin
            eff_len = CNT_W'(MAX_BITS);
        end else begin
            eff_len = bit_count[CNT_W-1:0];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        emit     = 1'b0;
        rd_idx   = s_q.idx + IDX_W'(1);
        unique case (s_q.st)
            SEQ_IDLE: begin
                rd_idx = '0;
                if (start) begin
                    if (eff_len == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st   = SEQ_RUN;
                        s_d.idx  = '0;
                        s_d.last = IDX_W'(eff_len - CNT_W'(1));
                        s_d.hold = hold_cycles;
                        s_d.dly  = hold_cycles;
                        emit     = 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (s_q.hold == '0) begin
                    if (s_q.idx == s_q.last) begin
                        s_d.st   = SEQ_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.idx  = s_q.idx + IDX_W'(1);
                        s_d.hold = s_q.dly;
                        emit     = 1'b1;
                    end
                end else begin
                    s_d.hold = s_q.hold - DLY_W'(1);
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st == SEQ_RUN);
    assign done = s_q.done;

endmodule

// File: rtl/bitpat_pin.sv
// Pin register: pattern bits have priority, direct writes only when idle.
module bitpat_pin #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic pat_bit,
    input  logic busy,
    input  logic set_en,
    input  logic set_val,
    output logic pin
);

    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (emit) begin
            pin_d = pat_bit;
        end else if (set_en && !busy) begin
            pin_d = set_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= RESET_LEVEL;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin = pin_q;

endmodule

// File: rtl/bitpat_tx.sv
module bitpat_tx #(
    parameter int DEPTH  = 32,
    parameter int LEN_W  = 16,
    parameter int DLY_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int NBITS = DEPTH * 8,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr_en,
    input  logic [AW-1:0]    buf_wr_addr,
    input  logic [7:0]       buf_wr_data,
    input  logic [LEN_W-1:0] bit_count,
    input  logic [DLY_W-1:0] hold_cycles,
    input  logic             start,
    input  logic             pin_set_en,
    input  logic             pin_set_val,
    output logic             pin_out,
    output logic             busy,
    output logic             done
);

    logic             emit;
    logic             pat_bit;
    logic [IDX_W-1:0] rd_idx;

    bitpat_seq #(
        .LEN_W    (LEN_W),
        .DLY_W    (DLY_W),
        .MAX_BITS (NBITS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .bit_count   (bit_count),
        .hold_cycles (hold_cycles),
        .busy        (busy),
        .done        (done),
        .emit        (emit),
        .rd_idx      (rd_idx)
    );

    bitpat_buf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .lock    (busy),
        .rd_idx  (rd_idx),
        .rd_bit  (pat_bit)
    );

    bitpat_pin #(
        .RESET_LEVEL (1'b0)
    ) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit    (emit),
        .pat_bit (pat_bit),
        .busy    (busy),
        .set_en  (pin_set_en),
        .set_val (pin_set_val),
        .pin     (pin_out)
    );

endmodule

// File: rtl/bitpat_tx_chk.sv
module bitpat_tx_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] bit_count,
    input logic             start,
    input logic             pin_set_en,
    input logic             pin_set_val,
    input logic             pin_out,
    input logic             busy,
    input logic             done
);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bit_count != '0) |=> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_keep_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $stable(pin_out));

    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bit_count == '0) |=> (done && !busy && $stable(pin_out)));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    p_idle_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && pin_set_en) |=> (pin_out == $past(pin_set_val)));

endmodule

bind bitpat_tx bitpat_tx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_count   (bit_count),
    .start       (start),
    .pin_set_en  (pin_set_en),
    .pin_set_val (pin_set_val),
    .pin_out     (pin_out),
    .busy        (busy),
    .done        (done)
);

// File: tb/bitpat_tx_bench.sv
`timescale 1ns/1ps
module bitpat_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_wr_en = 1'b0;
    logic [4:0]  buf_wr_addr = '0;
    logic [7:0]  buf_wr_data = '0;
    logic [15:0] bit_count = '0;
    logic [15:0] hold_cycles = '0;
    logic        start = 1'b0;
    logic        pin_set_en = 1'b0;
    logic        pin_set_val = 1'b0;
    logic        pin_out, busy, done;

    int   vectors = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    logic [7:0] model [32];
    logic exp_pin = 1'b0;

    always #4 clk = ~clk;

    bitpat_tx u_bitpat_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data),
        .bit_count   (bit_count),
        .hold_cycles (hold_cycles),
        .start       (start),
        .pin_set_en  (pin_set_en),
        .pin_set_val (pin_set_val),
        .pin_out     (pin_out),
        .busy        (busy),
        .done        (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int i);
        return model[i >> 3][7 - (i & 7)];
    endfunction

    task automatic t_reset();
        chk(pin_out == 1'b0, "R10 pin", int'(pin_out), 0);
        chk(busy == 1'b0, "R10 busy", int'(busy), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
    endtask

    task automatic t_load();
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            buf_wr_en   = 1'b1;
            buf_wr_addr = 5'(a);
            buf_wr_data = 8'((a * 37 + 11) ^ 8'h5A);
            model[a]    = buf_wr_data;
        end
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    // poke mask: 1 = start, 2 = pin write, 4 = buffer write, at cycle poke_at
    task automatic t_run(input int len, input int dly, input int poke_at,
                         input int mask, input string tg);
        int eff;
        int c;
        logic lastb;
        eff = (len > 256) ? 256 : len;
        @(negedge clk);
        bit_count   = 16'(len);
        hold_cycles = 16'(dly);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (eff == 0) begin
            chk(done == 1'b1 && busy == 1'b0, "R5 done", int'({busy, done}), 1);
            chk(pin_out == exp_pin, "R5 pin", int'(pin_out), int'(exp_pin));
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R5 end", int'({busy, done}), 0);
            chk(pin_out == exp_pin, "R5 pin kept", int'(pin_out), int'(exp_pin));
            return;
        end
        c = 0;
        for (int k = 0; k < eff; k++) begin
            for (int h = 0; h <= dly; h++) begin
                chk(pin_out == exp_bit(k), (k == 0 && h == 0) ? "R2 first bit" : tg,
                    int'(pin_out), int'(exp_bit(k)));
                chk(busy == 1'b1 && done == 1'b0, (k == 0 && h == 0) ? "R2 busy" : "R3 busy",
                    int'({busy, done}), 2);
                if (c == poke_at) begin
                    if (mask[0]) begin
                        start = 1'b1;
                        bit_count = 16'd5;
                        hold_cycles = 16'd0;
                    end
                    if (mask[1]) begin
                        pin_set_en  = 1'b1;
                        pin_set_val = ~pin_out;
                    end
                    if (mask[2]) begin
                        buf_wr_en   = 1'b1;
                        buf_wr_addr = 5'd0;
                        buf_wr_data = ~model[0];
                    end
                end else if (c == poke_at + 1) begin
                    start = 1'b0;
                    pin_set_en = 1'b0;
                    buf_wr_en = 1'b0;
                end
                c++;
                @(negedge clk);
            end
        end
        lastb = exp_bit(eff - 1);
        chk(busy == 1'b0 && done == 1'b1, "R3 end", int'({busy, done}), 1);
        chk(pin_out == lastb, "R4 last level", int'(pin_out), int'(lastb));
        exp_pin = lastb;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R3 done width", int'({busy, done}), 0);
        chk(pin_out == lastb, "R4 level kept", int'(pin_out), int'(lastb));
    endtask

    task automatic t_idle_set(input logic v);
        @(negedge clk);
        pin_set_en  = 1'b1;
        pin_set_val = v;
        @(negedge clk);
        pin_set_en = 1'b0;
        chk(pin_out == v, "R8 idle write", int'(pin_out), int'(v));
        exp_pin = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R10: buffer cleared by reset, a 4-bit run sends zeros
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        t_run(4, 0, -1, 0, "R10 buffer");
        t_load();
        t_run(11, 2, -1, 0, "R1 odd count");
        t_run(16, 0, -1, 0, "R1 two bytes");
        t_idle_set(1'b1);
        t_idle_set(1'b0);
        t_run(0, 3, -1, 0, "R5");
        t_run(300, 0, -1, 0, "R6 clipped");
        t_run(20, 1, 5, 1, "R7 start ignored");
        t_run(20, 1, 5, 2, "R8 busy write");
        t_run(20, 1, 5, 4, "R9 busy buffer");
        t_run(8, 0, -1, 0, "R9 byte kept");
        // R9: idle write stores the byte
        @(negedge clk);
        buf_wr_en = 1'b1; buf_wr_addr = 5'd0; buf_wr_data = 8'hA5; model[0] = 8'hA5;
        @(negedge clk);
        buf_wr_en = 1'b0;
        t_run(8, 3, -1, 0, "R9 idle write");
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule